// File: doc/BRIEF.md
# Four-Lane SD Read Block Receiver

This block is the receive side of a 4-bit SD card data path. Once it accepts a request, it drives the card clock. On every rising clock edge it samples the four data lines. It looks for the all-zero start nibble of each block and packs the data nibbles into 32-bit words. The first nibble received is the most significant nibble of each word, and the words leave on a one-cycle valid stream.

Each data line carries its own CRC16, so four independent checkers run side by side. Each checker takes in that line's data bits and then the 16 check bits that follow on the same line. A block whose four registers do not all return to zero counts as an error. A block with a bad closing nibble also counts as an error.

The block reports how many blocks are done and how many of them failed. A finished transfer ends in one of three states: clean, data-CRC failure, or timeout. The number of blocks is chosen per request. The block length, clock divider, request limit and timeout are parameters.

Top module: `sd_quad_rd_rx`

## Requirements
- R1: After reset, `busy`, `sd_clk`, `word_valid`, `blocks_done`, `crc_err_cnt`, `fin_ok`, `fin_crc` and `timeout` are all 0.
- R2: `sd_clk` stays 0 while idle. After the accepting edge of `start`, `sd_clk` first rises on clock edge CLK_DIV and then every 2*CLK_DIV edges. `dat_i` is sampled on each edge where `sd_clk` rises.
- R3: While waiting for a block, any sample with at least one line at 1 is ignored. A sample of 4'h0 marks the start of the block.
- R4: The start nibble is followed by BLOCK_BYTES*2 data nibbles, and `dat_i[3]` carries each nibble's MSB. Every 8 data nibbles form one word, with the earliest nibble in bits 31:28. That word is shown on `word_data` with `word_valid` high for the single cycle after the edge that sampled its last nibble.
- R5: Each line i runs its own CRC over polynomial x^16+x^12+x^5+1. The register starts at zero and takes that line's data bits, then 16 check bits sent MSB first. If any line's check fails, `crc_err_cnt` rises by 1 for that block.
- R6: The sample after the 16 check nibbles must be 4'hF. Any other value counts the block as an error in `crc_err_cnt`.
- R7: `blocks_done` rises by exactly 1 on the sample of each block's closing nibble, whether or not the block has an error. The receiver then waits for the next start nibble without a new request.
- R8: When `blocks_done` reaches the requested count, `busy` drops. Then `fin_ok` is set if `crc_err_cnt` is 0, and `fin_crc` is set otherwise.
- R9: The transfer may not be complete by clock edge TIMEOUT_CYC after the accepting edge. In that case `busy` drops, `timeout` is set and neither finish flag is set. A transfer whose closing nibble is sampled on edge TIMEOUT_CYC itself completes normally.
- R10: `start` is ignored while `busy` is high, and also when `blk_count` is 0 or greater than MAX_BLOCKS.
- R11: An accepted `start` clears `blocks_done`, `crc_err_cnt` and all three finish flags, and raises `busy` on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse for a new transfer |
| blk_count | input | $clog2(MAX_BLOCKS+1) | Number of blocks in the request |
| dat_i | input | 4 | Card data lines, bit 3 is nibble MSB |
| sd_clk | output | 1 | Card clock |
| busy | output | 1 | Transfer in progress |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | 32 | Assembled data word |
| blocks_done | output | $clog2(MAX_BLOCKS+1) | Blocks received so far |
| crc_err_cnt | output | $clog2(MAX_BLOCKS+1) | Blocks that failed CRC or closing-nibble check |
| fin_ok | output | 1 | Transfer ended with no errors |
| fin_crc | output | 1 | Transfer ended with at least one bad block |
| timeout | output | 1 | Transfer aborted by the timer |

## Verification
The block's final closing-nibble sample and the expiry of the timeout timer can land on the same clock edge. The bench provokes this by choosing the number of idle nibbles before a single block, so that the closing nibble is sampled exactly on edge TIMEOUT_CYC. It then repeats the run with one more idle nibble. The first run must end with `fin_ok` and no `timeout`. The second must end with `timeout` only and zero completed blocks.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rx_state_e;

  // one serial step of x^16+x^12+x^5+1, MSB-first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ ({16{fb}} & 16'h1021);
  endfunction

endpackage

// File: rtl/sdq_clkgen.sv
module sdq_clkgen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sd_clk,
  output logic rise
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic          clk_d;
  logic          wrap;

  assign wrap = (div_q == DW'(CLK_DIV - 1));
  assign rise = run && wrap && !sd_clk;

  always_comb begin
    div_d = div_q;
    clk_d = sd_clk;
    if (!(run && hold)) begin
      div_d = '0;
      clk_d = 1'b0;
    end else if (wrap) begin
      div_d = '0;
      clk_d = !sd_clk;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sd_clk <= 1'b0;
    end else begin
      div_q  <= div_d;
      sd_clk <= clk_d;
    end
  end

endmodule

// File: rtl/sdq_crc_lane.sv
module sdq_crc_lane
  import sdq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_i,
  output logic zero
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)       crc_d = '0;
    else if (step) crc_d = crc16_step(crc_q, bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign zero = (crc_q == 16'h0000);

endmodule

// File: rtl/sdq_packer.sv
module sdq_packer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [3:0]        nib,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  localparam int NIBS = WORD_W / 4;
  localparam int NW   = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic [NW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_d;
  logic              vld_d;

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = word;
    vld_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (push) begin
      sr_d  = {word[WORD_W-5:0], nib};
      vld_d = (cnt_q == NW'(NIBS - 1));
      cnt_d = vld_d ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      word       <= sr_d;
      word_valid <= vld_d;
    end
  end

endmodule

// File: rtl/sd_quad_rd_rx.sv
module sd_quad_rd_rx
  import sdq_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int MAX_BLOCKS  = 256,
  parameter int CLK_DIV     = 2,
  parameter int TIMEOUT_CYC = 1000000,
  localparam int BLK_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_count,
  input  logic [3:0]       dat_i,
  output logic             sd_clk,
  output logic             busy,
  output logic             word_valid,
  output logic [31:0]      word_data,
  output logic [BLK_W-1:0] blocks_done,
  output logic [BLK_W-1:0] crc_err_cnt,
  output logic             fin_ok,
  output logic             fin_crc,
  output logic             timeout
);
  localparam int DATA_NIBS = BLOCK_BYTES * 2;
  localparam int CRC_NIBS  = 16;
  localparam int CNT_W     = $clog2(DATA_NIBS);
  localparam int TMR_W     = $clog2(TIMEOUT_CYC + 1);
  localparam int LANES     = 4;

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] tgt_q, tgt_d, done_d, err_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             ok_d, crcf_d, tmo_d;
  logic             rise, start_ok, lane_clr, lane_step, push, blk_bad;
  logic             busy_d;
  logic [LANES-1:0] lane_zero;

  assign busy     = (st_q != ST_IDLE);
  assign busy_d   = (st_d != ST_IDLE);
  assign start_ok = start && (st_q == ST_IDLE) && (blk_count != '0) &&
                    (blk_count <= BLK_W'(MAX_BLOCKS));
  assign blk_bad  = !(&lane_zero) || (dat_i != 4'hF);

  sdq_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .hold(busy_d),
    .sd_clk(sd_clk), .rise(rise)
  );

  sdq_packer #(.WORD_W(32)) packer_i (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .push(push), .nib(dat_i),
    .word(word_data), .word_valid(word_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sdq_crc_lane lane_i (
      .clk(clk), .rst_n(rst_n), .clr(lane_clr), .step(lane_step),
      .bit_i(dat_i[g]), .zero(lane_zero[g])
    );
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    tgt_d     = tgt_q;
    done_d    = blocks_done;
    err_d     = crc_err_cnt;
    tmr_d     = tmr_q;
    ok_d      = fin_ok;
    crcf_d    = fin_crc;
    tmo_d     = timeout;
    lane_clr  = 1'b0;
    lane_step = 1'b0;
    push      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_ok) begin
        st_d   = ST_HUNT;
        tgt_d  = blk_count;
        done_d = '0;
        err_d  = '0;
        tmr_d  = '0;
        ok_d   = 1'b0;
        crcf_d = 1'b0;
        tmo_d  = 1'b0;
      end
      ST_HUNT: if (rise && dat_i == 4'h0) begin
        st_d     = ST_DATA;
        cnt_d    = '0;
        lane_clr = 1'b1;
      end
      ST_DATA: if (rise) begin
        push      = 1'b1;
        lane_step = 1'b1;
        if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
          st_d  = ST_CRC;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CRC: if (rise) begin
        lane_step = 1'b1;
        if (cnt_q == CNT_W'(CRC_NIBS - 1)) st_d = ST_END;
        else                               cnt_d = cnt_q + 1'b1;
      end
      ST_END: if (rise) begin
        done_d = blocks_done + 1'b1;
        err_d  = crc_err_cnt + BLK_W'(blk_bad);
        if (done_d == tgt_q) begin
          st_d = ST_IDLE;
          if (err_d == '0) ok_d   = 1'b1;
          else             crcf_d = 1'b1;
        end else begin
          st_d = ST_HUNT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    // timer: completion on the limit edge wins
    if (st_q != ST_IDLE && st_d != ST_IDLE) begin
      if (tmr_q == TMR_W'(TIMEOUT_CYC - 1)) begin
        st_d  = ST_IDLE;
        tmo_d = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      tgt_q       <= '0;
      blocks_done <= '0;
      crc_err_cnt <= '0;
      tmr_q       <= '0;
      fin_ok      <= 1'b0;
      fin_crc     <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      tgt_q       <= tgt_d;
      blocks_done <= done_d;
      crc_err_cnt <= err_d;
      tmr_q       <= tmr_d;
      fin_ok      <= ok_d;
      fin_crc     <= crcf_d;
      timeout     <= tmo_d;
    end
  end

  // R2
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sd_clk);

  // R4
  word_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(st_q == ST_DATA && rise));

  // R7
  blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (blocks_done == $past(blocks_done) ||
                     blocks_done == $past(blocks_done) + 1'b1));

  // R5
  err_at_block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_cnt != $past(crc_err_cnt)) |->
      ($past(!busy) || blocks_done != $past(blocks_done)));

  // R8
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ok |-> (crc_err_cnt == '0));

  // R9
  end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_ok, fin_crc, timeout}));

endmodule

// File: tb/sd_quad_rd_rx_tb_top.sv
`timescale 1ns/1ps
module sd_quad_rd_rx_tb_top;
  localparam int BB    = 8;
  localparam int MAXB  = 4;
  localparam int CDIV  = 2;
  localparam int TMO   = 4002;
  localparam int BW    = $clog2(MAXB + 1);
  localparam int WORDS = BB / 4;

  logic          clk, rst_n, start;
  logic [BW-1:0] blk_count;
  logic [3:0]    dat;
  logic          sd_clk, busy, word_valid, fin_ok, fin_crc, timeout;
  logic [31:0]   word_data;
  logic [BW-1:0] blocks_done, crc_err_cnt;

  int total, bad;
  bit finished;
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];
  longint rise_t[2];
  int rise_n;

  sd_quad_rd_rx #(.BLOCK_BYTES(BB), .MAX_BLOCKS(MAXB), .CLK_DIV(CDIV),
                  .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
    .dat_i(dat), .sd_clk(sd_clk), .busy(busy), .word_valid(word_valid),
    .word_data(word_data), .blocks_done(blocks_done),
    .crc_err_cnt(crc_err_cnt), .fin_ok(fin_ok), .fin_crc(fin_crc),
    .timeout(timeout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (word_valid) got_q.push_back(word_data);

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] r, input logic b);
    logic x;
    x = r[15] ^ b;
    r = {r[14:0], 1'b0};
    if (x) r = r ^ 16'h1021;
    return r;
  endfunction

  task automatic emit(input logic [3:0] n);
    dat = n;
    if (busy) @(posedge sd_clk or negedge busy);
    if (rise_n < 2) begin rise_t[rise_n] = $time; rise_n++; end
    #1;
  endtask

  task automatic send_block(input logic [31:0] seed, input int idle,
                            input bit bad_crc, input logic [3:0] endn);
    logic [15:0] crc[4];
    logic [3:0]  n;
    logic [31:0] d;
    for (int l = 0; l < 4; l++) crc[l] = '0;
    for (int i = 0; i < idle; i++) emit(4'hF);
    emit(4'h0);
    for (int w = 0; w < WORDS; w++) begin
      d = seed * 32'h9E3779B1 + w * 32'h01234567;
      exp_q.push_back(d);
      for (int k = 7; k >= 0; k--) begin
        n = d[k*4 +: 4];
        for (int l = 0; l < 4; l++) crc[l] = crc_upd(crc[l], n[l]);
        emit(n);
      end
    end
    if (bad_crc) crc[2][7] = ~crc[2][7];
    for (int j = 15; j >= 0; j--) begin
      for (int l = 0; l < 4; l++) n[l] = crc[l][j];
      emit(n);
    end
    emit(endn);
    dat = 4'hF;
  endtask

  longint t0;
  task automatic go(input int cnt);
    rise_n = 0;
    @(negedge clk);
    blk_count = BW'(cnt);
    start = 1'b1;
    @(posedge clk);
    t0 = $time;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_words(input string req);
    int mism;
    mism = 0;
    chk(req, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (got_q[i] !== exp_q[i]) mism++;
    chk(req, mism, 0);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 sd_clk", sd_clk, 0);
    chk("R1 word_valid", word_valid, 0);
    chk("R1 blocks_done", blocks_done, 0);
    chk("R1 crc_err_cnt", crc_err_cnt, 0);
    chk("R1 flags", {fin_ok, fin_crc, timeout}, 0);
  endtask

  task automatic t_single();
    dat = 4'h1;
    go(1);
    chk("R11 busy on start", busy, 1);
    emit(4'h1); emit(4'hE); emit(4'h8);
    send_block(32'h11, 1, 1'b0, 4'hF);
    chk("R2 first rise", rise_t[0] - t0, 8 * CDIV);
    chk("R2 second rise", rise_t[1] - t0, 8 * 3 * CDIV);
    wait_idle();
    chk("R2 clk idle", sd_clk, 0);
    chk_words("R3 R4 words");
    chk("R7 blocks_done", blocks_done, 1);
    chk("R8 fin_ok", fin_ok, 1);
    chk("R8 busy", busy, 0);
  endtask

  task automatic t_multi();
    go(3);
    chk("R11 cleared", {blocks_done, fin_ok, fin_crc, timeout}, 0);
    send_block(32'h21, 2, 1'b0, 4'hF);
    send_block(32'h22, 5, 1'b1, 4'hF);
    send_block(32'h23, 0, 1'b0, 4'hF);
    wait_idle();
    chk_words("R4 multi words");
    chk("R7 blocks_done", blocks_done, 3);
    chk("R5 crc_err_cnt", crc_err_cnt, 1);
    chk("R8 fin_crc", {fin_ok, fin_crc}, 2'b01);
  endtask

  task automatic t_bad_end();
    go(1);
    chk("R11 err cleared", crc_err_cnt, 0);
    send_block(32'h31, 0, 1'b0, 4'h7);
    wait_idle();
    got_q.delete(); exp_q.delete();
    chk("R6 crc_err_cnt", crc_err_cnt, 1);
    chk("R6 fin_crc", fin_crc, 1);
  endtask

  task automatic t_ignore();
    @(negedge clk); blk_count = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 zero count", busy, 0);
    @(negedge clk); blk_count = BW'(MAXB + 1); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 over max", busy, 0);
    go(1);
    @(negedge clk); blk_count = BW'(3); start = 1'b1;
    @(negedge clk); start = 1'b0;
    send_block(32'h41, 1, 1'b0, 4'hF);
    wait_idle();
    chk_words("R10 words");
    chk("R10 busy after one", busy, 0);
    chk("R10 fin_ok", fin_ok, 1);
  endtask

  task automatic t_timeout();
    go(2);
    send_block(32'h51, 0, 1'b0, 4'hF);
    wait_idle();
    chk_words("R9 words");
    chk("R9 timeout", timeout, 1);
    chk("R9 no fin", {fin_ok, fin_crc}, 0);
    chk("R9 blocks_done", blocks_done, 1);
  endtask

  task automatic t_collide();
    int w;
    w = (TMO - 2) / 4 - 33;
    go(1);
    send_block(32'h61, w, 1'b0, 4'hF);
    wait_idle();
    chk_words("R9 edge words");
    chk("R9 edge completes", {fin_ok, timeout}, 2'b10);
    go(1);
    send_block(32'h62, w + 1, 1'b0, 4'hF);
    wait_idle();
    got_q.delete(); exp_q.delete();
    chk("R9 late aborts", {fin_ok, fin_crc, timeout}, 3'b001);
    chk("R9 late blocks", blocks_done, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0; rise_n = 2;
    rst_n = 1'b0; start = 1'b0; blk_count = '0; dat = 4'hF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_multi();
    t_bad_end();
    t_ignore();
    t_timeout();
    t_collide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule